// File: doc/BRIEF.md
# Comparator Control and Interrupt Register

This block is the digital shell around an analog comparator. Software reaches it through one 8-bit register with a write strobe and a read-back path. The register holds a power-down control, a choice of positive input between the external pin and an internal reference, and a request to take the negative input from the converter's multiplexer. It also holds an interrupt enable and a two-bit edge mode.

The raw comparator decision arrives asynchronously. It passes through a multi-stage synchronizer, and the synchronized value can be read back. An edge detector compares the current synchronized sample with the previous one. When the edge chosen by the mode field appears, it raises an event flag. The flag is cleared when the processor acknowledges the interrupt vector, or when software writes a one to the flag's bit position. The interrupt request is the flag gated by the local enable and the global interrupt enable.

Top module: `cmp_ctrl_reg`

## Requirements
- R1: After reset, `rd_data` reads 0x00, `cmp_pwr_en` is 1, and `irq`, `pos_sel_ref` and `neg_sel_mux` are all 0.
- R2: Bits 7, 6, 3, 2, 1 and 0 store the value written on a cycle with `wr_en` high and read back unchanged. A write to bit 5 has no effect.
- R3: Bit 5 of `rd_data` shows `cmp_raw` after two rising clock edges. This means 1 to 2 cycles after the input changes.
- R4: With mode bits [1:0] = 00, any change of the synchronized output sets the event flag (bit 4). The flag is visible one edge after the synchronized output changes.
- R5: With mode 01, no change of the comparator output ever sets the flag.
- R6: With mode 10, only a 1-to-0 change sets the flag.
- R7: With mode 11, only a 0-to-1 change sets the flag.
- R8: Writing 1 to bit 4 clears the flag. Writing 0 to bit 4 leaves it unchanged.
- R9: A one-cycle pulse on `irq_ack` clears the flag.
- R10: When a set event and a clear arrive on the same edge, the flag ends up set.
- R11: `irq` is 1 exactly when the flag, bit 3 (interrupt enable) and `gie` are all 1.
- R12: `cmp_pwr_en` is the inverse of bit 7. Synchronization and edge detection keep running while bit 7 is 1.
- R13: `pos_sel_ref` follows bit 6. A value of 1 selects the internal reference.
- R14: `neg_sel_mux` is 1 only when bit 2 is 1 and `adc_on` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read-back |
| cmp_raw | input | 1 | Asynchronous raw comparator output |
| adc_on | input | 1 | Converter enabled status |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt vector acknowledge pulse |
| cmp_pwr_en | output | 1 | Comparator power enable |
| pos_sel_ref | output | 1 | Positive input selects the internal reference |
| neg_sel_mux | output | 1 | Negative input taken from the converter multiplexer |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume three things about the inputs. `irq_ack` is a single-cycle pulse. `cmp_raw` is a clean digital level once it has passed the synchronizer. No write arrives while the block is in reset. The bench drives every input one time unit after a rising edge, so each input is stable across the edge that samples it. It holds `cmp_raw` at 0 through reset, so no edge is seen just as reset is released.

// File: rtl/cmp_ctrl_pkg.sv
package cmp_ctrl_pkg;
  localparam int REG_W = 8;
  localparam int B_OFF = 7;
  localparam int B_REF = 6;
  localparam int B_OUT = 5;
  localparam int B_EVT = 4;
  localparam int B_IEN = 3;
  localparam int B_MUX = 2;

  typedef enum logic [1:0] {
    MODE_ANY  = 2'b00,
    MODE_NONE = 2'b01,
    MODE_FALL = 2'b10,
    MODE_RISE = 2'b11
  } edge_mode_e;

  typedef struct packed {
    logic       off;
    logic       use_ref;
    logic       ien;
    logic       mux_en;
    edge_mode_e mode;
  } ctrl_t;

  function automatic logic edge_hit(edge_mode_e m, logic cur, logic prv);
    logic hit;
    case (m)
      MODE_ANY:  hit = cur ^ prv;
      MODE_FALL: hit = prv & ~cur;
      MODE_RISE: hit = cur & ~prv;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

  function automatic logic [REG_W-1:0] pack_reg(ctrl_t c, logic cout, logic evt);
    logic [REG_W-1:0] v;
    v        = '0;
    v[B_OFF] = c.off;
    v[B_REF] = c.use_ref;
    v[B_OUT] = cout;
    v[B_EVT] = evt;
    v[B_IEN] = c.ien;
    v[B_MUX] = c.mux_en;
    v[1:0]   = c.mode;
    return v;
  endfunction
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync
  import cmp_ctrl_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw_in,
  input  edge_mode_e mode,
  output logic       sync_out,
  output logic       prev_out,
  output logic       hit
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] chain_q;
  logic         prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      if (STAGES > 1) chain_q <= {chain_q[TOP-1:0], raw_in};
      else            chain_q <= raw_in;
      prev_q <= chain_q[TOP];
    end
  end

  assign sync_out = chain_q[TOP];
  assign prev_out = prev_q;
  assign hit      = edge_hit(mode, sync_out, prev_out);

  // R4
  edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (sync_out != prev_out));

  // R5
  none_mode_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_NONE) |-> !hit);
endmodule

// File: rtl/cmp_flag.sv
module cmp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_sw,
  input  logic clr_ack,
  output logic flag
);
  logic flag_q;
  logic clr_any;

  assign clr_any = clr_sw | clr_ack;

  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr_any) flag_q <= 1'b0;
  end

  assign flag = flag_q;

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q);

  // R8
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_any && !set_evt) |=> !flag_q);

  // R4
  rise_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_evt));
endmodule

// File: rtl/cmp_ctrl_bank.sv
module cmp_ctrl_bank
  import cmp_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output ctrl_t            ctrl,
  output logic             clr_sw
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q.off     <= wr_data[B_OFF];
      ctrl_q.use_ref <= wr_data[B_REF];
      ctrl_q.ien     <= wr_data[B_IEN];
      ctrl_q.mux_en  <= wr_data[B_MUX];
      ctrl_q.mode    <= edge_mode_e'(wr_data[1:0]);
    end
  end

  assign ctrl   = ctrl_q;
  assign clr_sw = wr_en & wr_data[B_EVT];

  // R2
  hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/cmp_ctrl_reg.sv
module cmp_ctrl_reg
  import cmp_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       cmp_raw,
  input  logic       adc_on,
  input  logic       gie,
  input  logic       irq_ack,
  output logic       cmp_pwr_en,
  output logic       pos_sel_ref,
  output logic       neg_sel_mux,
  output logic       irq
);
  ctrl_t ctrl;
  logic  clr_sw;
  logic  sync_out;
  logic  prev_out;
  logic  hit;
  logic  flag;

  cmp_ctrl_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl    (ctrl),
    .clr_sw  (clr_sw)
  );

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (cmp_raw),
    .mode     (ctrl.mode),
    .sync_out (sync_out),
    .prev_out (prev_out),
    .hit      (hit)
  );

  cmp_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (hit),
    .clr_sw  (clr_sw),
    .clr_ack (irq_ack),
    .flag    (flag)
  );

  assign rd_data     = pack_reg(ctrl, sync_out, flag);
  assign cmp_pwr_en  = ~ctrl.off;
  assign pos_sel_ref = ctrl.use_ref;
  assign neg_sel_mux = ctrl.mux_en & ~adc_on;
  assign irq         = flag & ctrl.ien & gie;

  // R11
  irq_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (gie && rd_data[B_EVT]));

  // R9
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !hit) |=> !rd_data[B_EVT]);
endmodule

// File: tb/cmp_ctrl_reg_bench.sv
module cmp_ctrl_reg_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       cmp_raw = 1'b0;
  logic       adc_on = 1'b0;
  logic       gie = 1'b0;
  logic       irq_ack = 1'b0;
  logic       cmp_pwr_en, pos_sel_ref, neg_sel_mux, irq;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_ctrl_reg u_cmp_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .cmp_raw(cmp_raw), .adc_on(adc_on), .gie(gie), .irq_ack(irq_ack),
    .cmp_pwr_en(cmp_pwr_en), .pos_sel_ref(pos_sel_ref), .neg_sel_mux(neg_sel_mux), .irq(irq)
  );

  // {mode[1:0], start level, end level, expected flag}
  localparam logic [4:0] EDGE_VEC [8] = '{
    {2'b00, 1'b0, 1'b1, 1'b1},  // R4 toggle up
    {2'b00, 1'b1, 1'b0, 1'b1},  // R4 toggle down
    {2'b01, 1'b0, 1'b1, 1'b0},  // R5
    {2'b01, 1'b1, 1'b0, 1'b0},  // R5
    {2'b10, 1'b0, 1'b1, 1'b0},  // R6 rise ignored
    {2'b10, 1'b1, 1'b0, 1'b1},  // R6 fall
    {2'b11, 1'b0, 1'b1, 1'b1},  // R7 rise
    {2'b11, 1'b1, 1'b0, 1'b0}   // R7 fall ignored
  };

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    tick(3);
    // R1 reset state
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 pwr_en", cmp_pwr_en, 1);
    chk("R1 irq", irq, 0);
    chk("R1 pos", pos_sel_ref, 0);
    chk("R1 neg", neg_sel_mux, 0);
    rst_n = 1'b1;
    tick();

    // R2 writable bits, bit 5 ignored, bit 4 write-one clears
    wr(8'hFF);
    chk("R2 all ones", rd_data, 8'hCF);
    wr(8'h00);
    chk("R2 zeros", rd_data, 8'h00);

    // Edge table
    for (int i = 0; i < 8; i++) begin
      logic [1:0] m;
      m = EDGE_VEC[i][4:3];
      cmp_raw = EDGE_VEC[i][2];
      wr({6'b000100, m});
      tick(4);
      wr({6'b000100, m});
      tick();
      cmp_raw = EDGE_VEC[i][1];
      tick(4);
      chk($sformatf("R4-7 vector %0d flag", i), rd_data[4], EDGE_VEC[i][0]);
    end

    // R3 sync delay (mode 01: no flag)
    wr(8'h11);
    cmp_raw = 1'b0;
    tick(4);
    cmp_raw = 1'b1;
    tick();
    chk("R3 after one edge", rd_data[5], 0);
    tick();
    chk("R3 after two edges", rd_data[5], 1);

    // R12 power-down with edges still detected
    cmp_raw = 1'b0;
    wr(8'h93);
    tick(4);
    chk("R12 pwr_en low", cmp_pwr_en, 0);
    wr(8'h93);
    cmp_raw = 1'b1;
    tick(4);
    chk("R12 edge while off", rd_data[4], 1);

    // R8 write zero keeps, write one clears
    wr(8'h83);
    chk("R8 write zero keeps flag", rd_data[4], 1);
    wr(8'h13);
    chk("R8 write one clears", rd_data[4], 0);
    chk("R12 pwr_en high", cmp_pwr_en, 1);

    // R9 ack clears
    cmp_raw = 1'b0;
    tick(4);
    cmp_raw = 1'b1;
    tick(4);
    chk("R9 flag set", rd_data[4], 1);
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
    chk("R9 ack clears", rd_data[4], 0);

    // R10 set and clear on the same edge
    cmp_raw = 1'b0;
    tick(4);
    wr(8'h13);
    cmp_raw = 1'b1;
    tick(2);
    wr(8'h13);
    chk("R10 set wins", rd_data[4], 1);

    // R11 irq gating
    gie = 1'b0;
    wr(8'h03);
    chk("R11 ien off", irq, 0);
    wr(8'h0B);
    chk("R11 gie off", irq, 0);
    gie = 1'b1;
    #1;
    chk("R11 all on", irq, 1);
    wr(8'h1B);
    chk("R11 flag cleared", irq, 0);

    // R13 positive select
    wr(8'h40);
    chk("R13 ref selected", pos_sel_ref, 1);
    wr(8'h00);
    chk("R13 pin selected", pos_sel_ref, 0);

    // R14 negative select
    wr(8'h04);
    adc_on = 1'b0;
    #1;
    chk("R14 mux when adc off", neg_sel_mux, 1);
    adc_on = 1'b1;
    #1;
    chk("R14 pin when adc on", neg_sel_mux, 0);

    // R1 reset again clears everything
    wr(8'hCF);
    rst_n = 1'b0;
    tick();
    chk("R1 reset clears", rd_data & 8'hDF, 8'h00);
    rst_n = 1'b1;
    tick();

    summary();
  end
endmodule